// File: doc/BRIEF.md
# Pipelined Hyperbolic Exponential Evaluator

This block computes e^theta in fixed point. An upstream unit has already split the argument as theta = Q·ln2 + gamma. The block receives the small residue gamma and the integer Q. A chain of hyperbolic rotation stages turns gamma into e^gamma. A final shift stage multiplies that by 2^Q, and the result leaves as e^theta scaled by 2^16.

The two coordinates of a hyperbolic rotation start equal here and follow the same update, so only one coordinate chain and the angle chain are built. The x chain starts from the reciprocal of the hyperbolic gain. Every stage is registered, so one new argument can enter on every clock. Q and a valid flag travel alongside the data, delayed to match it.

Top module: `hyp_exp_pipe`

## Requirements
- R1: The pipeline accepts one argument per clock with no stall. A valid argument sampled at a rising edge appears with out_valid high exactly 16 rising edges later, counting the sampling edge as the first: 15 rotation stages plus one scaling register.
- R2: The 15 stages use the shift indices 1,2,3,4,4,5,6,7,8,9,10,11,12,13,13, with index 4 and index 13 applied twice. The angle constant of each stage is atanh(2^-i), held at 2^20 scaling.
- R3: Each stage picks its rotation direction from the sign of its residual angle. A residual of zero or above counts as positive: x grows by x·2^-i and the angle drops by the constant. A negative residual does the opposite.
- R4: Only x and the angle are iterated, with x_{i+1} = x_i ± x_i·2^-i. x starts at 1/K of the 15-stage schedule, so with Q = 0 the result is e^gamma·2^16.
- R5: in_gamma is a signed 20-bit two's-complement value at 2^16 scaling. The result converges for any |gamma| up to about 1.1, which covers negative residues as well as the usual range [0, ln2).
- R6: in_q is a signed 5-bit integer. The scaling stage shifts left for a positive net exponent and arithmetic-right for a negative one, so the result is x·2^Q truncated toward zero at 2^16 scaling. The bench uses Q in [-9, 8].
- R7: out_exp is an unsigned 32-bit e^theta·2^16. For theta in [-6, 6], it stays within 0.3% plus one unit of the value exact for the quantised gamma. For example, theta = 1 gives about 178142, theta = 0 gives about 65536, and theta = -6 gives about 162.
- R8: Q and the valid flag are delay-matched to the data. When out_valid is low, out_exp reads 0.
- R9: Reset is synchronous and active low. It clears every valid flag, so out_valid and out_exp are 0 after any clock edge taken in reset, including one taken mid-stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Argument present this cycle |
| in_q | input | 5 | Signed integer part Q of theta/ln2 |
| in_gamma | input | 20 | Signed residue gamma, 2^16 scaling |
| out_valid | output | 1 | Result present this cycle |
| out_exp | output | 32 | e^theta·2^16, zero when not valid |

## Verification
A new argument entering the first stage and an older result leaving the scaling register share every cycle of a back-to-back stream. The same holds when consecutive arguments need opposite shift directions. The bench streams a dense sweep over [-6, 6] in which the sign of Q alternates from cycle to cycle, and it places bubbles between valid items. Every cycle it judges both the valid timing and the value: the value against a real-number exponential with the relative bound, and a zero output during bubbles. A reset in the middle of a stream checks that no argument already inside the pipeline survives.

// File: rtl/hexp_pkg.sv
// Package: shared widths, gain constant and stage schedule for the
// hyperbolic exponential pipeline.
// Assumes an internal fraction of 20 bits: the angle table is held at 2^20.
package hexp_pkg;
    localparam int XW       = 24;             // internal x / z width
    localparam int GUARD    = 4;              // guard bits below the 2^16 grid
    localparam int FRAC_IN  = 16;             // scaling of gamma and output
    localparam int FRAC_INT = FRAC_IN + GUARD;
    localparam int GW       = XW - GUARD;     // width of gamma input
    localparam int QW       = 5;              // width of Q
    localparam int OW       = 32;             // width of result
    localparam int NSTAGE   = 15;             // rotation stages
    localparam int LATENCY  = NSTAGE + 1;     // stages plus scaling register

    // 1/K for the 15-stage repeat schedule, at 2^20 scaling
    localparam logic signed [XW-1:0] INV_GAIN = 24'sd1266152;

    // Shift index of stage k: indices 4, 13, 40, ... are visited twice
    function automatic int stage_index(int k);
        int  idx   = 1;
        int  rep   = 4;
        bit  again = 1'b0;
        for (int s = 0; s < k; s++) begin
            if (idx == rep && !again) begin
                again = 1'b1;
            end else begin
                if (idx == rep) rep = 3 * rep + 1;
                again = 1'b0;
                idx++;
            end
        end
        return idx;
    endfunction

    // atanh(2^-i) at 2^20 scaling; beyond i = 7 the value equals 2^-i
    function automatic logic signed [XW-1:0] atanh_const(int i);
        case (i)
            1: return 24'sd575989;
            2: return 24'sd267820;
            3: return 24'sd131761;
            4: return 24'sd65622;
            5: return 24'sd32779;
            6: return 24'sd16385;
            7: return 24'sd8192;
            default: return 24'sd1 <<< (FRAC_INT - i);
        endcase
    endfunction
endpackage

// File: rtl/hyp_rot_stage.sv
// One registered hyperbolic rotation step on the merged x chain and the
// angle chain. Assumes x stays positive and |z| lies within the reach
// of the remaining stages; Q and valid ride along unchanged.
module hyp_rot_stage
    import hexp_pkg::*;
#(
    parameter int                     IDX = 1,
    parameter logic signed [XW-1:0]   ANG = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic signed [QW-1:0] q_i,
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] z_i,
    output logic                 v_o,
    output logic signed [QW-1:0] q_o,
    output logic signed [XW-1:0] x_o,
    output logic signed [XW-1:0] z_o
);
    logic                 up;
    logic signed [XW-1:0] x_sh;
    logic signed [XW-1:0] x_nxt;
    logic signed [XW-1:0] z_nxt;

    // Rotation direction and next coordinate values
    always_comb begin
        up    = (z_i >= 0);
        x_sh  = x_i >>> IDX;
        x_nxt = up ? (x_i + x_sh) : (x_i - x_sh);
        z_nxt = up ? (z_i - ANG)  : (z_i + ANG);
    end

    // Valid flag register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) v_o <= 1'b0;
        else        v_o <= v_i;
    end

    // Data registers, loaded only for valid items
    always_ff @(posedge clk) begin
        if (v_i) begin
            x_o <= x_nxt;
            z_o <= z_nxt;
            q_o <= q_i;
        end
    end

    assert_valid_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |=> v_o);
    assert_idle_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !v_i |=> !v_o);
    assert_q_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |=> (q_o == $past(q_i)));
    assert_grow_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && z_i >= 0) |=> (x_o >= $past(x_i)));
    assert_shrink_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && z_i < 0) |=> (x_o <= $past(x_i)));
endmodule

// File: rtl/exp_pow2_scale.sv
// Registered power-of-two scaling: multiplies e^gamma (2^20 grid) by 2^Q
// and returns e^theta on the 2^16 grid. Assumes a positive x and Q small
// enough that the result fits the output width; output is 0 when idle.
module exp_pow2_scale
    import hexp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic signed [QW-1:0] q_i,
    input  logic signed [XW-1:0] x_i,
    output logic                 v_o,
    output logic [OW-1:0]        y_o
);
    localparam int WW = OW + XW;

    int                   net_sh;
    logic signed [WW-1:0] wide;
    logic signed [WW-1:0] wide_sh;
    logic [OW-1:0]        y_nxt;

    // Net shift: exponent Q minus the guard bits dropped on output
    always_comb begin
        net_sh = int'(q_i) - GUARD;
        wide   = {{(WW-XW){x_i[XW-1]}}, x_i};
        if (net_sh >= 0) wide_sh = wide <<< net_sh;
        else             wide_sh = wide >>> (-net_sh);
        y_nxt  = wide_sh[OW-1:0];
    end

    // Output register, forced to zero for idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            y_o <= '0;
        end else begin
            v_o <= v_i;
            y_o <= v_i ? y_nxt : '0;
        end
    end

    assert_zero_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !v_i |=> (y_o == '0));
    assert_result_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        v_o |-> !y_o[OW-1]);
endmodule

// File: rtl/hyp_exp_pipe.sv
// Top of the exponential evaluator: seeds x with 1/K and z with gamma,
// runs the 15-stage hyperbolic schedule, then scales by 2^Q.
// Assumes upstream range reduction delivers |gamma| below about 1.1.
module hyp_exp_pipe
    import hexp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [QW-1:0] in_q,
    input  logic signed [GW-1:0] in_gamma,
    output logic                 out_valid,
    output logic [OW-1:0]        out_exp
);
    logic                 v_s [NSTAGE+1];
    logic signed [QW-1:0] q_s [NSTAGE+1];
    logic signed [XW-1:0] x_s [NSTAGE+1];
    logic signed [XW-1:0] z_s [NSTAGE+1];

    // Seed values for the first stage
    always_comb begin
        v_s[0] = in_valid;
        q_s[0] = in_q;
        x_s[0] = INV_GAIN;
        z_s[0] = {in_gamma, {GUARD{1'b0}}};
    end

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        localparam int IDX = stage_index(k);
        hyp_rot_stage #(
            .IDX (IDX),
            .ANG (atanh_const(IDX))
        ) u_rot (
            .clk   (clk),
            .rst_n (rst_n),
            .v_i   (v_s[k]),
            .q_i   (q_s[k]),
            .x_i   (x_s[k]),
            .z_i   (z_s[k]),
            .v_o   (v_s[k+1]),
            .q_o   (q_s[k+1]),
            .x_o   (x_s[k+1]),
            .z_o   (z_s[k+1])
        );
    end

    exp_pow2_scale u_scale (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (v_s[NSTAGE]),
        .q_i   (q_s[NSTAGE]),
        .x_i   (x_s[NSTAGE]),
        .v_o   (out_valid),
        .y_o   (out_exp)
    );

    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_exp == '0));
    assert_positive_x_R4: assert property (@(posedge clk) disable iff (!rst_n)
        v_s[NSTAGE] |-> (x_s[NSTAGE] > 0));
endmodule

// File: tb/sim_hyp_exp_pipe.sv
`timescale 1ns/1ps
module sim_hyp_exp_pipe;
    localparam int  LAT = 16;
    localparam real LN2 = 0.69314718055994531;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic signed [4:0] in_q;
    logic signed [19:0] in_gamma;
    logic              out_valid;
    logic [31:0]       out_exp;

    int    nchk = 0;
    int    nbad = 0;
    bit    done = 0;
    bit    pv [LAT];
    real   pe [LAT];
    string pt [LAT];
    real   cur_exp;
    string cur_tag;

    always #2 clk = ~clk;

    hyp_exp_pipe u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_q(in_q),
        .in_gamma(in_gamma), .out_valid(out_valid), .out_exp(out_exp)
    );

    // Reference pipeline: shifts the expected item every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) pv[k] = 1'b0;
        end else begin
            for (int k = LAT-1; k > 0; k--) begin
                pv[k] = pv[k-1]; pe[k] = pe[k-1]; pt[k] = pt[k-1];
            end
            pv[0] = in_valid; pe[0] = cur_exp; pt[0] = cur_tag;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            nchk++;
            if (out_valid !== pv[LAT-1]) begin
                nbad++;
                $display("FAIL R1 valid timing: actual %0b expected %0b", out_valid, pv[LAT-1]);
            end else if (pv[LAT-1]) begin
                real d;
                d = $itor(out_exp) - pe[LAT-1];
                if (d < 0.0) d = -d;
                if (d > 0.003 * pe[LAT-1] + 1.5) begin
                    nbad++;
                    $display("FAIL %s value: actual %0d expected %0d", pt[LAT-1], out_exp, $rtoi(pe[LAT-1]));
                end
            end else if (out_exp !== 32'd0) begin
                nbad++;
                $display("FAIL R8 idle output: actual %0d expected 0", out_exp);
            end
        end
    end

    task automatic send_raw(int q, int gfx, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_q     = 5'(q);
        in_gamma = 20'(gfx);
        cur_exp  = $pow(2.0, q) * $exp($itor(gfx) / 65536.0) * 65536.0;
        cur_tag  = tag;
    endtask

    task automatic send_theta(real th, string tag);
        int  q;
        real g;
        q = $rtoi($floor(th / LN2));
        g = th - q * LN2;
        send_raw(q, $rtoi($floor(g * 65536.0)), tag);
    endtask

    task automatic bubble();
        @(negedge clk);
        in_valid = 1'b0;
        in_q     = 5'sd7;
        in_gamma = 20'sh5A5A5;
    endtask

    task automatic check_reset_state();
        nchk++;
        if (out_valid !== 1'b0 || out_exp !== 32'd0) begin
            nbad++;
            $display("FAIL R9 reset state: actual %0b/%0d expected 0/0", out_valid, out_exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_q = '0; in_gamma = '0;
        cur_exp = 0.0; cur_tag = "R7";
        repeat (3) @(posedge clk);
        @(negedge clk); check_reset_state();
        rst_n = 1'b1;

        // Reference points named in R7
        send_theta(1.0, "R7");
        send_theta(0.0, "R7");
        send_theta(-6.0, "R7");
        send_theta(6.0, "R7");
        // Q = 0 gives e^gamma directly (R4); both direction signs (R3)
        send_raw(0, 0, "R4");
        send_raw(0, 45000, "R4");
        send_raw(0, -32768, "R3");
        send_raw(0, -65536, "R5");
        send_raw(0, 65536, "R5");
        send_raw(0, 72000, "R2");
        send_raw(0, -72000, "R2");
        // Alternating exponent sign, back to back (R6, R1)
        for (int k = 1; k <= 8; k++) begin
            send_theta(k * 0.7, "R6");
            send_theta(-k * 0.7, "R6");
        end
        // Dense sweep over [-6, 6] without gaps (R1, R7)
        for (int k = -24; k <= 24; k++) send_theta(k * 0.25, "R1");
        // Bubbles interleaved with valid items (R8)
        for (int k = 0; k < 10; k++) begin
            send_theta(-5.0 + k, "R8");
            bubble();
            if (k % 3 == 0) bubble();
        end
        repeat (LAT + 4) bubble();

        // Reset in mid-stream drops everything in flight (R9)
        for (int k = 0; k < 6; k++) send_theta(0.5 * k, "R9");
        @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk); check_reset_state();
        rst_n = 1'b1;
        repeat (LAT + 4) bubble();
        send_theta(2.0, "R9");
        repeat (LAT + 4) bubble();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
        $finish;
    end
endmodule